// File: doc/BRIEF.md
# Clustered Page Table Walker

This block resolves a translation miss by searching a clustered, hashed page table held in word-addressed memory. A request carries a virtual page number, the base address of the bucket array and the number of buckets. The two low bits of the page number give a block offset. The remaining upper bits form a block number, and that block number is hashed to pick one bucket slot. The slot holds the pointer to the first node of a chain.

Each node covers four neighbouring pages. It holds one block-number tag, a pointer to the next node and four frame entries. The walker issues one memory read at a time. It compares each node's tag with the requested block number and moves along the chain until a tag matches, the chain ends or a length limit is reached. On a match it fetches only the entry chosen by the block offset. It then reports the frame and attribute bits, a miss, or an error.

Memory layout, in words: bucket slot `i` lies at `base + i`. A node at pointer `p` keeps its tag at `p`, its next pointer at `p+1` and its entries at `p+2` through `p+5`. An entry word carries the frame number in bits [19:0] and four attribute bits in [23:20]. Attribute bit 0, which is bit 20 of the entry word, is the valid flag. A pointer value of zero means null.

Top module: `cpt_walker`

## Requirements
- R1: The block number is `vpn_i >> 2`, and the block offset is `vpn_i[1:0]`.
- R2: The first read goes to `base_i + (block number & (bucket_cnt_i - 1))`. `bucket_cnt_i` must be a power of two. A zero head pointer ends the walk as a miss with no further reads.
- R3: For each node at pointer `p`, the walker reads the tag at `p` and then the next pointer at `p+1`, in that order.
- R4: If the tag differs and the next pointer is nonzero, the walk continues at that pointer. If the tag differs and the next pointer is zero, the result is a miss.
- R5: On a tag match the walker makes exactly one more read, at `p+2+offset`. It then returns `frame_o` = entry[19:0] and `attr_o` = entry[23:20], with `hit_o` = 1.
- R6: If the selected entry has attribute bit 0 clear, the result is a miss: `hit_o`=0 and `err_o`=0.
- R7: After 16 nodes with no match, a nonzero next pointer in the 16th node ends the walk with `err_o`=1 and no 17th node read. A 16-node chain whose last next pointer is zero is a plain miss.
- R8: `done_o` is high for exactly one cycle. That cycle is the one after the final read is accepted. The result outputs hold until the next request starts.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` accepts the read.
- R10: `start_i` is ignored while `busy_o` is high.
- R11: After reset, `busy_o`, `mem_req_o`, `done_o`, `hit_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a walk when the block is idle |
| vpn_i | input | 20 | Virtual page number |
| base_i | input | 16 | Word address of the bucket array |
| bucket_cnt_i | input | 16 | Number of buckets (a power of two) |
| busy_o | output | 1 | A walk is in progress |
| mem_req_o | output | 1 | Read request to table memory |
| mem_addr_o | output | 16 | Word address of the read |
| mem_rvalid_i | input | 1 | Read data valid; accepts the pending request |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Translation found with valid entry |
| err_o | output | 1 | Chain length limit exceeded |
| frame_o | output | 20 | Physical frame number |
| attr_o | output | 4 | Entry attribute bits, bit 0 = valid |

## Verification
The hardest case to reach is the chain-length boundary. A request must land in a bucket whose chain is at least 16 nodes long, and the result has to be compared against chains just below, exactly at and beyond the limit. The stimulus fills one bucket with a 20-node chain. It queries a block number found in node 16, which must hit, one found in node 17, which must give an error, and one absent from the chain. A separate bucket holds a chain of exactly 16 nodes ending in a null pointer, which must give a plain miss. A second `start_i` is also driven in the middle of a long, slow walk to show that a busy walker ignores it.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_TAG,
    ST_NEXT,
    ST_ENT
  } walk_st_e;
endpackage

// File: rtl/cpt_hash.sv
module cpt_hash #(
  parameter int VPN_W  = 20,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  localparam int VPBN_W = VPN_W - OFF_W
) (
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] bucket_cnt_i,
  output logic [VPBN_W-1:0] vpbn_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [ADDR_W-1:0] head_addr_o
);
  logic [ADDR_W-1:0] vb_t;

  assign vpbn_o = vpn_i[VPN_W-1:OFF_W];
  assign off_o  = vpn_i[OFF_W-1:0];

  generate
    if (VPBN_W >= ADDR_W) begin : g_trunc
      assign vb_t = vpbn_o[ADDR_W-1:0];
    end else begin : g_ext
      assign vb_t = ADDR_W'(vpbn_o);
    end
  endgenerate

  assign head_addr_o = base_i + (vb_t & (bucket_cnt_i - ADDR_W'(1)));
endmodule

// File: rtl/cpt_entry_dec.sv
module cpt_entry_dec #(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 20,
  parameter int ATTR_W  = 4
) (
  input  logic [DATA_W-1:0]  word_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [ATTR_W-1:0]  attr_o,
  output logic               valid_o
);
  assign frame_o = word_i[FRAME_W-1:0];
  assign attr_o  = word_i[FRAME_W+ATTR_W-1:FRAME_W];
  assign valid_o = attr_o[0];
endmodule

// File: rtl/cpt_node_cnt.sv
module cpt_node_cnt #(
  parameter int MAX_NODES = 16,
  localparam int CNT_W = $clog2(MAX_NODES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_limit_o = (cnt_q == CNT_W'(MAX_NODES));

  // R7: never count past the limit
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_NODES));
endmodule

// File: rtl/cpt_walker.sv
module cpt_walker
  import cpt_pkg::*;
#(
  parameter int VPN_W     = 20,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int FRAME_W   = 20,
  parameter int ATTR_W    = 4,
  parameter int MAX_NODES = 16,
  localparam int OFF_W    = 2,
  localparam int VPBN_W   = VPN_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  bucket_cnt_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               done_o,
  output logic               hit_o,
  output logic               err_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [ATTR_W-1:0]  attr_o
);
  walk_st_e          state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q, bcnt_q, ptr_q;
  logic              match_q;

  logic [VPBN_W-1:0] vpbn;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] head_addr;
  logic [FRAME_W-1:0] ent_frame;
  logic [ATTR_W-1:0]  ent_attr;
  logic               ent_valid;
  logic               at_limit, cnt_clr, cnt_inc;
  logic               rd_null, tag_eq;

  cpt_hash #(.VPN_W(VPN_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_hash (
    .vpn_i(vpn_q), .base_i(base_q), .bucket_cnt_i(bcnt_q),
    .vpbn_o(vpbn), .off_o(off), .head_addr_o(head_addr)
  );

  cpt_entry_dec #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .ATTR_W(ATTR_W)) u_dec (
    .word_i(mem_rdata_i), .frame_o(ent_frame), .attr_o(ent_attr), .valid_o(ent_valid)
  );

  cpt_node_cnt #(.MAX_NODES(MAX_NODES)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .at_limit_o(at_limit)
  );

  assign rd_null   = (mem_rdata_i == '0);
  assign tag_eq    = (mem_rdata_i == DATA_W'(vpbn));
  assign busy_o    = (state_q != ST_IDLE);
  assign mem_req_o = busy_o;
  assign cnt_clr   = (state_q == ST_IDLE) && start_i;
  assign cnt_inc   = mem_rvalid_i && !rd_null &&
                     ((state_q == ST_HEAD) ||
                      (state_q == ST_NEXT && !match_q && !at_limit));

  always_comb begin
    unique case (state_q)
      ST_HEAD: mem_addr_o = head_addr;
      ST_TAG:  mem_addr_o = ptr_q;
      ST_NEXT: mem_addr_o = ptr_q + ADDR_W'(1);
      ST_ENT:  mem_addr_o = ptr_q + ADDR_W'(2) + ADDR_W'(off);
      default: mem_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      bcnt_q  <= '0;
      ptr_q   <= '0;
      match_q <= 1'b0;
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      err_o   <= 1'b0;
      frame_o <= '0;
      attr_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vpn_q   <= vpn_i;
          base_q  <= base_i;
          bcnt_q  <= bucket_cnt_i;
          state_q <= ST_HEAD;
        end
        ST_HEAD: if (mem_rvalid_i) begin
          if (rd_null) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            hit_o   <= 1'b0;
            err_o   <= 1'b0;
            frame_o <= '0;
            attr_o  <= '0;
          end else begin
            ptr_q   <= mem_rdata_i[ADDR_W-1:0];
            state_q <= ST_TAG;
          end
        end
        ST_TAG: if (mem_rvalid_i) begin
          match_q <= tag_eq;
          state_q <= ST_NEXT;
        end
        ST_NEXT: if (mem_rvalid_i) begin
          if (match_q) begin
            state_q <= ST_ENT;
          end else if (rd_null || at_limit) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            hit_o   <= 1'b0;
            err_o   <= !rd_null;
            frame_o <= '0;
            attr_o  <= '0;
          end else begin
            ptr_q   <= mem_rdata_i[ADDR_W-1:0];
            state_q <= ST_TAG;
          end
        end
        ST_ENT: if (mem_rvalid_i) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          hit_o   <= ent_valid;
          err_o   <= 1'b0;
          frame_o <= ent_frame;
          attr_o  <= ent_attr;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: pending read keeps its address
  a_r9_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8: completion leaves the walker idle
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R6: hit and error never together
  a_r6_hit_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(hit_o && err_o));
  // R11: no request without a walk
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

// File: tb/cpt_walker_bench.sv
module cpt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] vpn = '0;
  logic [15:0] base = '0;
  logic [15:0] bcnt = '0;
  logic        busy, mem_req, mem_rvalid, done, hit, err;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [19:0] frame;
  logic [3:0]  attr;

  always #4 clk = ~clk;

  cpt_walker u_cpt_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vpn_i(vpn), .base_i(base),
    .bucket_cnt_i(bcnt), .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done), .hit_o(hit),
    .err_o(err), .frame_o(frame), .attr_o(attr)
  );

  bit [31:0] mem [int];
  int exp_q [$];
  int lat = 0;
  int dly = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_req = "R3";

  function automatic int rd(int a);
    return mem.exists(a) ? int'(mem[a]) : 0;
  endfunction

  // memory responder with programmable latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      dly        <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
    end else if (mem_req) begin
      if (dly >= lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= 32'(rd(int'(mem_addr)));
        dly        <= 0;
      end else dly <= dly + 1;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // every accepted read is compared with the model's read sequence
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_rvalid) begin
      if (exp_q.size() == 0) chk(0, cur_req, longint'(mem_addr), -1);
      else begin
        chk(int'(mem_addr) == exp_q[0], cur_req, longint'(mem_addr), longint'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic model(input int v, input int b, input int c,
                       output bit h, output bit e, output int fr, output int at);
    int vb, off, a, p, n, w;
    vb = v >> 2; off = v & 3;
    h = 0; e = 0; fr = 0; at = 0;
    exp_q.delete();
    a = (b + (vb & (c - 1))) & 'hffff;
    exp_q.push_back(a);
    p = rd(a);
    if (p == 0) return;
    n = 0;
    forever begin
      n++;
      exp_q.push_back(p);
      exp_q.push_back(p + 1);
      if (rd(p) == vb) begin
        exp_q.push_back(p + 2 + off);
        w = rd(p + 2 + off);
        at = (w >> 20) & 15; fr = w & 'hfffff; h = at[0];
        return;
      end
      if (rd(p + 1) == 0) return;
      if (n == 16) begin e = 1; return; end
      p = rd(p + 1);
    end
  endtask

  function automatic int ent(int valid, int a3, int fr);
    return (((a3 << 1) | valid) << 20) | fr;
  endfunction

  task automatic put_node(int p, int tag, int nxt, int e0, int e1, int e2, int e3);
    mem[p] = tag; mem[p+1] = nxt;
    mem[p+2] = e0; mem[p+3] = e1; mem[p+4] = e2; mem[p+5] = e3;
  endtask

  task automatic run(int vb, int off, int b, int c, int l, string req, bit poke);
    bit eh, ee; int ef, ea; bit seen;
    int held_f;
    lat = l;
    cur_req = req;
    model((vb << 2) | off, b, c, eh, ee, ef, ea);
    @(negedge clk);
    start = 1'b1; vpn = 20'((vb << 2) | off); base = 16'(b); bcnt = 16'(c);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      chk(busy, "R10", longint'(busy), 1);
      start = 1'b1; vpn = 20'(4 << 2); base = 16'h0200; bcnt = 16'd2;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(seen, "R8", longint'(seen), 1);
    chk(hit == eh, req, longint'(hit), longint'(eh));
    chk(err == ee, ee ? "R7" : req, longint'(err), longint'(ee));
    if (eh) begin
      chk(frame == 20'(ef), "R5", longint'(frame), longint'(ef));
      chk(attr == 4'(ea), "R5", longint'(attr), longint'(ea));
    end
    chk(exp_q.size() == 0, ee ? "R7" : req, longint'(exp_q.size()), 0);
    held_f = int'(frame);
    @(negedge clk);
    chk(!done, "R8", longint'(done), 0);
    chk(hit == eh && int'(frame) == held_f && !busy, "R8", longint'(hit), longint'(eh));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // bucket array at 0x100, 8 buckets
    mem[16'h101] = 'h400;
    put_node('h400, 1, 0, ent(1, 0, 'h11), ent(1, 3, 'h22), ent(0, 7, 'h33), ent(1, 5, 'h44));
    mem[16'h102] = 'h410;
    put_node('h410, 10, 'h420, ent(1, 1, 'h1a0), ent(1, 1, 'h1a1), ent(1, 1, 'h1a2), ent(1, 1, 'h1a3));
    put_node('h420, 18, 'h430, ent(1, 2, 'h120), 0, 0, 0);
    put_node('h430, 2, 0, ent(1, 4, 'h200), ent(1, 4, 'h201), ent(1, 6, 'h202), ent(1, 4, 'h203));
    mem[16'h105] = 'h500;
    for (int k = 0; k < 20; k++)
      put_node('h500 + 8*k, 13 + 8*k, (k == 19) ? 0 : 'h500 + 8*(k+1),
               ent(1, 1, 'h5000 + k), ent(1, 1, 'h5100 + k), ent(1, 1, 'h5200 + k), ent(1, 1, 'h5300 + k));
    mem[16'h106] = 'h600;
    for (int k = 0; k < 16; k++)
      put_node('h600 + 8*k, 14 + 8*k, (k == 15) ? 0 : 'h600 + 8*(k+1),
               ent(1, 0, 'h6000 + k), 0, 0, 0);
    mem[16'h201] = 'h400;

    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !hit && !err, "R11", longint'({busy, mem_req, done, hit, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !done, "R11", longint'({busy, mem_req, done}), 0);

    run(3, 0, 'h100, 8, 0, "R2", 0);         // empty bucket
    run(1, 0, 'h100, 8, 0, "R1", 0);         // offset 0
    run(1, 1, 'h100, 8, 1, "R5", 0);         // offset 1
    run(1, 3, 'h100, 8, 2, "R1", 0);         // offset 3
    run(1, 2, 'h100, 8, 0, "R6", 0);         // invalid entry
    run(10, 2, 'h100, 8, 0, "R3", 0);        // first node of chain
    run(2, 2, 'h100, 8, 1, "R4", 0);         // third node of chain
    run(26, 0, 'h100, 8, 0, "R4", 0);        // chain end, miss
    run(133, 3, 'h100, 8, 0, "R7", 0);       // 16th node hits
    run(141, 0, 'h100, 8, 1, "R7", 0);       // 17th node beyond limit
    run(5, 0, 'h100, 8, 0, "R7", 0);         // long chain, no match
    run(6, 0, 'h100, 8, 0, "R7", 0);         // exactly 16 nodes, null end
    run(5, 1, 'h100, 4, 0, "R2", 0);         // mask 3 -> bucket 1, tag mismatch
    run(1, 3, 'h100, 4, 0, "R2", 0);
    run(1, 1, 'h200, 2, 3, "R2", 0);         // other base
    run(2, 1, 'h100, 8, 2, "R10", 1);        // start while busy

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule